// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block gathers interrupt requests from a set of device slots and presents them to a single processor. Each slot holds a pending flag, a two-bit level code and a vector word. The block picks a winner in two steps. It first takes the highest level among the pending slots. Among the slots at that level, it then takes the lowest slot index. It raises `irq_out` when the winning level is strictly above the processor's current priority.

The processor fetches the vector through a dedicated acknowledge exchange, separate from ordinary data reads. The acknowledge is a valid/ready input stream (`ack_valid`/`ack_ready`). The answer is a valid/ready output stream (`rsp_valid`/`rsp_ready`) that carries the vector and a spurious flag.

The block holds at most one answer at a time:
- While an answer waits, `ack_ready` is low.
- A waiting answer keeps every field unchanged until `rsp_ready` takes it.
- The winner is fixed at the cycle the acknowledge is accepted. Later posts cannot change that answer.

Devices load their slot through a plain post port. The post port has no back-pressure and is always taken.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset:
  - no slot is pending;
  - `irq_out` is 0 and `irq_lvl` is 0;
  - `rsp_valid` is 0 and `ack_ready` is 1.
- R2: A cycle with `post_en` high stores `post_lvl` and `post_vec` in slot `post_slot` and marks that slot pending. Level code c (0..3) stands for priority level 4+c. Posting to a slot that is already pending overwrites its level and vector.
- R3: `irq_lvl` shows 4 plus the largest level code among pending slots, or 0 when nothing is pending. A higher level always wins over a lower one.
- R4: Among pending slots at the winning level, the lowest slot index is the winner.
- R5: `irq_out` is 1 exactly when some slot is pending and `irq_lvl` is strictly greater than the 3-bit `cpu_pri`.
- R6: An acknowledge is accepted on a cycle with `ack_valid` and `ack_ready` both high. On the next cycle:
  - `rsp_valid` is 1, `rsp_vec` holds the winner's vector and `rsp_spur` is 0;
  - the winner's pending flag is already cleared;
  - every other pending slot stays pending.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0:
  - `rsp_vec` and `rsp_spur` hold steady;
  - `ack_ready` is 0;
  - posts made during the wait do not change the answer.

  The answer leaves on the first cycle with `rsp_ready` high.
- R8: An acknowledge accepted while nothing is pending answers with `rsp_vec` = 0 and `rsp_spur` = 1.
- R9: If a post targets the winning slot in the same cycle that an acknowledge is accepted:
  - the answer carries the old vector;
  - the slot stays pending with the newly posted level and vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_en | input | 1 | Load a slot and mark it pending |
| post_slot | input | SLOT_W | Slot to load |
| post_lvl | input | 2 | Level code (level = 4 + code) |
| post_vec | input | VEC_W | Vector word for the slot |
| cpu_pri | input | 3 | Current processor priority |
| irq_out | output | 1 | Request to the processor |
| irq_lvl | output | 3 | Winning level, 0 when idle |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge can be taken |
| rsp_valid | output | 1 | Answer available |
| rsp_ready | input | 1 | Processor takes the answer |
| rsp_vec | output | VEC_W | Returned vector |
| rsp_spur | output | 1 | Acknowledge found nothing pending |

## Verification
The embedded properties check four things on every cycle:
- a waiting answer is held stable, and no second acknowledge is accepted while it waits;
- spurious answers carry a zero vector;
- the chosen slot is actually pending at the reported level;
- an acknowledged slot is retired unless a simultaneous post reloads it.

Some behaviour depends on the whole pattern of pending requests, and only the bench scenarios can show it:
- that the lowest index wins within a level;
- that level dominates index;
- the strict comparison against `cpu_pri`;
- the full ordering in which a crowded set of requests drains.

The bench sweeps every pending mask over eight slots with varied level codes, and drains each mask to a spurious answer.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef logic [LVL_W-1:0] lvl_code_t;

  // Map a two-bit level code to the 3-bit priority it stands for.
  function automatic logic [2:0] lvl_num(input lvl_code_t c);
    return {1'b1, c};
  endfunction
endpackage

// File: rtl/irq_slot_bank.sv
module irq_slot_bank
  import irq_res_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VEC_W     = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             post_en,
  input  logic [SLOT_W-1:0]                post_slot,
  input  lvl_code_t                        post_lvl,
  input  logic [VEC_W-1:0]                 post_vec,
  input  logic                             clr_en,
  input  logic [SLOT_W-1:0]                clr_slot,
  output logic [NUM_SLOTS-1:0]             pend,
  output logic [NUM_SLOTS-1:0][LVL_W-1:0]  lvl,
  output logic [NUM_SLOTS-1:0][VEC_W-1:0]  vec
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit_post, hit_clr;
    assign hit_post = post_en && (post_slot == SLOT_W'(s));
    assign hit_clr  = clr_en  && (clr_slot  == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[s] <= 1'b0;
        lvl[s]  <= '0;
        vec[s]  <= '0;
      end else if (hit_post) begin
        // A post outranks a retire of the same slot.
        pend[s] <= 1'b1;
        lvl[s]  <= post_lvl;
        vec[s]  <= post_vec;
      end else if (hit_clr) begin
        pend[s] <= 1'b0;
      end
    end
  end

  AST_POST_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    post_en |=> pend[$past(post_slot)] && (lvl[$past(post_slot)] == $past(post_lvl))) // R9
    else $error("post did not land");

endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
  import irq_res_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SLOTS-1:0]             pend,
  input  logic [NUM_SLOTS-1:0][LVL_W-1:0]  lvl,
  output logic                             hit,
  output lvl_code_t                        top_code,
  output logic [SLOT_W-1:0]                win
);

  logic [NUM_LVL-1:0] lvl_any;
  logic               found;

  // Which levels have at least one pending slot.
  always_comb begin
    lvl_any = '0;
    for (int l = 0; l < NUM_LVL; l++)
      for (int s = 0; s < NUM_SLOTS; s++)
        if (pend[s] && (lvl[s] == LVL_W'(l))) lvl_any[l] = 1'b1;
  end

  // Level first: the last hit in an ascending scan is the highest level.
  always_comb begin
    hit      = |lvl_any;
    top_code = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (lvl_any[l]) top_code = LVL_W'(l);
  end

  // Then position: the lowest slot index at that level.
  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (!found && pend[s] && (lvl[s] == top_code)) begin
        win   = SLOT_W'(s);
        found = 1'b1;
      end
  end

  AST_WIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pend[win] && (lvl[win] == top_code)) // R4
    else $error("winner not pending at top level");

  AST_HIT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (|pend)) // R3
    else $error("hit disagrees with pending set");

endmodule

// File: rtl/irq_ack_ctl.sv
module irq_ack_ctl
  import irq_res_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VEC_W     = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ack_valid,
  output logic                             ack_ready,
  output logic                             rsp_valid,
  input  logic                             rsp_ready,
  output logic [VEC_W-1:0]                 rsp_vec,
  output logic                             rsp_spur,
  input  logic                             hit,
  input  logic [SLOT_W-1:0]                win,
  input  logic [NUM_SLOTS-1:0][VEC_W-1:0]  vec,
  output logic                             clr_en,
  output logic [SLOT_W-1:0]                clr_slot
);

  logic accept;

  // Only one answer is held at a time.
  assign ack_ready = !rsp_valid;
  assign accept    = ack_valid && ack_ready;
  assign clr_en    = accept && hit;
  assign clr_slot  = win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_vec   <= '0;
      rsp_spur  <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_vec   <= hit ? vec[win] : '0;
      rsp_spur  <= !hit;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_vec) && $stable(rsp_spur)) // R7
    else $error("answer changed while waiting");

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !ack_ready) // R7
    else $error("acknowledge open while answer waits");

  AST_SPUR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_spur) |-> (rsp_vec == '0)) // R8
    else $error("spurious answer with nonzero vector");

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_res_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VEC_W     = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_en,
  input  logic [SLOT_W-1:0] post_slot,
  input  logic [1:0]        post_lvl,
  input  logic [VEC_W-1:0]  post_vec,
  input  logic [2:0]        cpu_pri,
  output logic              irq_out,
  output logic [2:0]        irq_lvl,
  input  logic              ack_valid,
  output logic              ack_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VEC_W-1:0]  rsp_vec,
  output logic              rsp_spur
);

  logic [NUM_SLOTS-1:0]             pend;
  logic [NUM_SLOTS-1:0][LVL_W-1:0]  lvl;
  logic [NUM_SLOTS-1:0][VEC_W-1:0]  vec;
  logic                             hit;
  lvl_code_t                        top_code;
  logic [SLOT_W-1:0]                win;
  logic                             clr_en;
  logic [SLOT_W-1:0]                clr_slot;

  irq_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W), .SLOT_W(SLOT_W)) u_bank (
    .clk, .rst_n, .post_en, .post_slot, .post_lvl, .post_vec,
    .clr_en, .clr_slot, .pend, .lvl, .vec
  );

  irq_level_sel #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_sel (
    .clk, .rst_n, .pend, .lvl, .hit, .top_code, .win
  );

  irq_ack_ctl #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W), .SLOT_W(SLOT_W)) u_ack (
    .clk, .rst_n, .ack_valid, .ack_ready, .rsp_valid, .rsp_ready,
    .rsp_vec, .rsp_spur, .hit, .win, .vec, .clr_en, .clr_slot
  );

  assign irq_lvl = hit ? lvl_num(top_code) : 3'd0;
  assign irq_out = hit && (irq_lvl > cpu_pri);

  AST_WIN_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(post_en && (post_slot == clr_slot))) |=> !pend[$past(clr_slot)]) // R6
    else $error("acknowledged slot still pending");

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|pend)) // R5
    else $error("request raised with nothing pending");

endmodule

// File: tb/sim_irq_prio_resolver.sv
module sim_irq_prio_resolver;
  localparam int NS = 8;
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          post_en = 1'b0;
  logic [2:0]    post_slot = '0;
  logic [1:0]    post_lvl = '0;
  logic [VW-1:0] post_vec = '0;
  logic [2:0]    cpu_pri = '0;
  logic          irq_out;
  logic [2:0]    irq_lvl;
  logic          ack_valid = 1'b0;
  logic          ack_ready;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [VW-1:0] rsp_vec;
  logic          rsp_spur;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit      pend_m [NS];
  int      lvl_m  [NS];
  int      vec_m  [NS];

  always #10 clk = ~clk;

  irq_prio_resolver #(.NUM_SLOTS(NS), .VEC_W(VW)) u0 (
    .clk, .rst_n, .post_en, .post_slot, .post_lvl, .post_vec, .cpu_pri,
    .irq_out, .irq_lvl, .ack_valid, .ack_ready, .rsp_valid, .rsp_ready,
    .rsp_vec, .rsp_spur
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_win();
    for (int l = 3; l >= 0; l--)
      for (int s = 0; s < NS; s++)
        if (pend_m[s] && lvl_m[s] == l) return s;
    return -1;
  endfunction

  function automatic int model_lvl();
    int w = model_win();
    return (w < 0) ? 0 : 4 + lvl_m[w];
  endfunction

  task automatic post(input int s, input int l, input int v);
    @(negedge clk);
    post_en = 1'b1; post_slot = 3'(s); post_lvl = 2'(l); post_vec = VW'(v);
    @(negedge clk);
    post_en = 1'b0;
    pend_m[s] = 1; lvl_m[s] = l; vec_m[s] = v;
  endtask

  // Acknowledge with rsp_ready high; check the answer and the remaining level.
  task automatic ack_once();
    int w = model_win();
    @(negedge clk);
    check("R6 ack_ready", int'(ack_ready), 1);
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    check("R6 rsp_valid", int'(rsp_valid), 1);
    if (w < 0) begin
      check("R8 spur vec", int'(rsp_vec), 0);
      check("R8 spur flag", int'(rsp_spur), 1);
    end else begin
      check("R4 vector", int'(rsp_vec), vec_m[w]);
      check("R6 spur flag", int'(rsp_spur), 0);
      pend_m[w] = 0;
    end
    check("R6 remaining level", int'(irq_lvl), model_lvl());
    @(negedge clk);
    check("R7 drained", int'(rsp_valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin pend_m[s] = 0; lvl_m[s] = 0; vec_m[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_out", int'(irq_out), 0);
    check("R1 irq_lvl", int'(irq_lvl), 0);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 ack_ready", int'(ack_ready), 1);

    // Sweep every pending mask with varied level codes (R3, R4, R5, R6, R8).
    for (int t = 0; t < 256; t++) begin
      for (int s = 0; s < NS; s++)
        if ((t >> s) & 1) post(s, (t + s * (t >> 3)) & 3, 16'h8000 | ((t << 3) & 16'h7ff8) | s);
      check("R3 irq_lvl", int'(irq_lvl), model_lvl());
      for (int p = 0; p < 8; p++) begin
        cpu_pri = 3'(p);
        #1;
        check("R5 irq_out", int'(irq_out), (model_lvl() > p) ? 1 : 0);
      end
      cpu_pri = 3'd0;
      while (model_win() >= 0) ack_once();
      ack_once();  // R8: nothing left, spurious answer
    end

    // R2: repost overwrites level and vector
    post(3, 0, 16'h1234);
    post(3, 2, 16'h4321);
    check("R2 overwrite level", int'(irq_lvl), 6);
    ack_once();

    // R7: back-pressure holds the answer; later posts do not change it
    post(2, 3, 16'hA5A5);
    @(negedge clk);
    rsp_ready = 1'b0; ack_valid = 1'b1;
    @(negedge clk);
    pend_m[2] = 0;
    post(1, 3, 16'h1111);
    repeat (2) @(negedge clk);
    check("R7 held valid", int'(rsp_valid), 1);
    check("R7 held vector", int'(rsp_vec), 16'hA5A5);
    check("R7 ack blocked", int'(ack_ready), 0);
    check("R7 level during hold", int'(irq_lvl), 7);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R7 released", int'(rsp_valid), 0);
    @(negedge clk);
    ack_valid = 1'b0;
    check("R7 next answer", int'(rsp_vec), 16'h1111);
    pend_m[1] = 0;
    @(negedge clk);
    check("R7 idle level", int'(irq_lvl), 0);

    // R9: post to the winner in the accept cycle
    post(0, 3, 16'h0AAA);
    @(negedge clk);
    ack_valid = 1'b1;
    post_en = 1'b1; post_slot = 3'd0; post_lvl = 2'd1; post_vec = 16'h0BBB;
    @(negedge clk);
    ack_valid = 1'b0; post_en = 1'b0;
    check("R9 old vector", int'(rsp_vec), 16'h0AAA);
    check("R9 slot still pending", int'(irq_lvl), 5);
    lvl_m[0] = 1; vec_m[0] = 16'h0BBB;
    @(negedge clk);
    ack_once();
    check("R9 empty after", int'(irq_lvl), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule